// File: doc/BRIEF.md
# CAN Single-Buffer Interface Controller

This block is the register-side controller for a CAN node that runs with no message memory. One register set holds a single outgoing frame. A second register set holds the last incoming frame. A host reaches both through a small synchronous write port and a combinational read port. The protocol core sits on the other side. It takes a frame through a load strobe and reports completion, lost arbitration, errors and received frames. It also exposes its live shift-register contents.

To send a frame, the host fills the transmit buffer and sets the transmit busy bit. While busy is set, the buffer is frozen. Once the core reports an idle bus, the buffer is handed over with a one-cycle load pulse. If arbitration is lost or an error occurs, the request stays pending and is reloaded at the next idle bus. A successful transfer clears busy and unlocks the buffer. Clearing busy by hand aborts the request and cancels any further retries.

Every frame the core receives is stored with no filtering. A new-data flag and a lost-message flag track overwrites. The host can also capture the live shift register at any moment, even in the middle of a frame.

The transmit side is a three-state machine:
- `TX_IDLE`: the buffer is writable. It goes to `TX_PEND` on a request write.
- `TX_PEND`: waiting for the bus. It goes back to `TX_IDLE` on an abort write. It goes to `TX_ACTIVE` when the bus is idle, and the load pulse is issued on that edge.
- `TX_ACTIVE`: the frame is on the bus. It goes to `TX_IDLE` on an abort write or on done. It goes to `TX_PEND` on lost arbitration or error.

If an abort write and a core event arrive in the same cycle, the abort wins.

Top module: `canb_ifbuf_ctrl`

Register map (4-bit address, 32-bit data). Any field not listed reads 0.

| Address | Register | Contents |
|---|---|---|
| 0 | TXCMD | Bit 0 is the transmit busy bit. Bits 31..1 are ignored on write. |
| 1 | TXARB | Identifier, bits ID_W-1..0 |
| 2 | TXCTL | DLC, bits 3..0 |
| 3 | TXD0 | Payload bits 31..0 |
| 4 | TXD1 | Payload bits 63..32 |
| 8 | RXCMD | Writing 1 to bit 0 takes a snapshot. Always reads 0. |
| 9 | RXARB | Received identifier |
| 10 | RXCTL | Bit 15 is new-data, bit 14 is lost-message, bits 3..0 are DLC. Any write clears both flags. |
| 11 | RXD0 | Received payload bits 31..0 |
| 12 | RXD1 | Received payload bits 63..32 |

## Requirements
- R1: After reset, TXCMD, RXARB and RXCTL read 0, and core_load is low.
- R2: Writing TXCMD with bit 0 = 1 while not busy makes TXCMD bit 0 read 1 from the next cycle on. Bits 31..1 of that write are ignored.
- R3: While TXCMD bit 0 is 1, writes to TXARB, TXCTL, TXD0 and TXD1 leave their read-back values and the core_tx_* outputs unchanged.
- R4: core_load pulses for exactly one cycle. It pulses only in a cycle where a request is pending, core_idle is 1 and no abort is being written. core_tx_id, core_tx_dlc and core_tx_data then equal the transmit buffer.
- R5: core_done while a frame is active clears TXCMD bit 0 on the next cycle, and the buffer becomes writable again.
- R6: core_arb_lost or core_err while active, with no abort, keeps TXCMD bit 0 at 1. core_load pulses again at the next cycle with core_idle = 1.
- R7: Writing TXCMD with bit 0 = 0 while busy (pending or active) clears busy on the next cycle. No load follows, even after a later core_err, core_arb_lost or core_idle.
- R8: core_rx_valid copies core_sh_id, core_sh_dlc and core_sh_data into RXARB, RXCTL[3:0], RXD0 and RXD1, and sets RXCTL bit 15.
- R9: core_rx_valid while RXCTL bit 15 is already 1 sets RXCTL bit 14.
- R10: Any write to RXCTL clears bits 15 and 14. The other RXCTL bits, apart from the DLC, always read 0.
- R11: Writing RXCMD with bit 0 = 1 copies the live shift-register inputs into the receive buffer without changing bits 15 and 14. Writing RXCMD with bit 0 = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 32 | Host read data (combinational) |
| core_idle | input | 1 | Core reports the bus idle |
| core_load | output | 1 | One-cycle strobe that hands the frame to the core |
| core_tx_id | output | ID_W | Transmit identifier |
| core_tx_dlc | output | 4 | Transmit DLC |
| core_tx_data | output | 64 | Transmit payload |
| core_done | input | 1 | Transmission completed |
| core_arb_lost | input | 1 | Arbitration lost |
| core_err | input | 1 | Transmission error |
| core_rx_valid | input | 1 | A received frame is in the shift register |
| core_sh_id | input | ID_W | Live shift-register identifier |
| core_sh_dlc | input | 4 | Live shift-register DLC |
| core_sh_data | input | 64 | Live shift-register payload |

## Verification
The assertions assume the following about the core side:
- core_done, core_arb_lost and core_err are single-cycle pulses.
- They arrive only after a frame has been loaded.
- core_idle is held low while a loaded frame is on the bus.

The bench's core model follows these rules. It drops core_idle right after each load. It raises exactly one completion indication at a time. It drives host writes on the falling edge, so they never collide with core events unless a test calls for that.

The case of an abort write in the same cycle as core_idle is driven on purpose, to show that the abort wins.

// File: rtl/canb_pkg.sv
package canb_pkg;
    localparam int HOST_W = 32;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 4;
    localparam int NWORDS = DATA_W / HOST_W;

    localparam logic [ADDR_W-1:0] A_TXCMD = 4'd0;
    localparam logic [ADDR_W-1:0] A_TXARB = 4'd1;
    localparam logic [ADDR_W-1:0] A_TXCTL = 4'd2;
    localparam logic [ADDR_W-1:0] A_TXD0  = 4'd3;
    localparam logic [ADDR_W-1:0] A_RXCMD = 4'd8;
    localparam logic [ADDR_W-1:0] A_RXARB = 4'd9;
    localparam logic [ADDR_W-1:0] A_RXCTL = 4'd10;
    localparam logic [ADDR_W-1:0] A_RXD0  = 4'd11;

    localparam int NEWDAT_BIT = 15;
    localparam int MSGLST_BIT = 14;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_PEND   = 2'd1,
        TX_ACTIVE = 2'd2
    } tx_state_e;
endpackage

// File: rtl/canb_tx_path.sv
module canb_tx_path
    import canb_pkg::*;
#(
    parameter int ID_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_req,
    input  logic              buf_wr_arb,
    input  logic              buf_wr_ctl,
    input  logic [NWORDS-1:0] buf_wr_dat,
    input  logic [HOST_W-1:0] wdata,
    input  logic              core_idle,
    input  logic              core_done,
    input  logic              core_arb_lost,
    input  logic              core_err,
    output logic              busy,
    output logic              core_load,
    output logic [ID_W-1:0]   tx_id,
    output logic [DLC_W-1:0]  tx_dlc,
    output logic [DATA_W-1:0] tx_data
);
    tx_state_e st, nxt;
    logic      abort_wr;

    assign abort_wr = cmd_wr && !cmd_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:   if (cmd_wr && cmd_req) nxt = TX_PEND;
            TX_PEND:   if (abort_wr)          nxt = TX_IDLE;
                       else if (core_idle)    nxt = TX_ACTIVE;
            TX_ACTIVE: if (abort_wr)          nxt = TX_IDLE;
                       else if (core_done)    nxt = TX_IDLE;
                       else if (core_arb_lost || core_err) nxt = TX_PEND;
            default:   nxt = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (st != TX_IDLE);
        core_load = (st == TX_PEND) && core_idle && !abort_wr;
    end

    // transmit buffer, writable only while not busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_id  <= '0;
            tx_dlc <= '0;
        end else if (!busy) begin
            if (buf_wr_arb) tx_id  <= wdata[ID_W-1:0];
            if (buf_wr_ctl) tx_dlc <= wdata[DLC_W-1:0];
        end
    end

    logic [HOST_W-1:0] dword [NWORDS];
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                        dword[w] <= '0;
            else if (!busy && buf_wr_dat[w])   dword[w] <= wdata;
        end
        assign tx_data[w*HOST_W +: HOST_W] = dword[w];
    end
endmodule

// File: rtl/canb_rx_path.sv
module canb_rx_path
    import canb_pkg::*;
#(
    parameter int ID_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              snap,
    input  logic              ctl_clr,
    input  logic [ID_W-1:0]   sh_id,
    input  logic [DLC_W-1:0]  sh_dlc,
    input  logic [DATA_W-1:0] sh_data,
    output logic [ID_W-1:0]   rx_id,
    output logic [DLC_W-1:0]  rx_dlc,
    output logic [DATA_W-1:0] rx_data,
    output logic              newdat,
    output logic              msglst
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_id   <= '0;
            rx_dlc  <= '0;
            rx_data <= '0;
        end else if (rx_valid || snap) begin
            rx_id   <= sh_id;
            rx_dlc  <= sh_dlc;
            rx_data <= sh_data;
        end
    end

    // a stored frame wins over a same-cycle clear; an overwrite is lost only if unread
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newdat <= 1'b0;
            msglst <= 1'b0;
        end else if (rx_valid) begin
            newdat <= 1'b1;
            msglst <= newdat && !ctl_clr;
        end else if (ctl_clr) begin
            newdat <= 1'b0;
            msglst <= 1'b0;
        end
    end
endmodule

// File: rtl/canb_ifbuf_ctrl.sv
module canb_ifbuf_ctrl
    import canb_pkg::*;
#(
    parameter int ID_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HOST_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HOST_W-1:0] rd_data,
    input  logic              core_idle,
    output logic              core_load,
    output logic [ID_W-1:0]   core_tx_id,
    output logic [DLC_W-1:0]  core_tx_dlc,
    output logic [DATA_W-1:0] core_tx_data,
    input  logic              core_done,
    input  logic              core_arb_lost,
    input  logic              core_err,
    input  logic              core_rx_valid,
    input  logic [ID_W-1:0]   core_sh_id,
    input  logic [DLC_W-1:0]  core_sh_dlc,
    input  logic [DATA_W-1:0] core_sh_data
);
    logic              tx_busy;
    logic              rx_newdat, rx_msglst;
    logic [ID_W-1:0]   rx_id;
    logic [DLC_W-1:0]  rx_dlc;
    logic [DATA_W-1:0] rx_data;
    logic [NWORDS-1:0] dat_wr;

    for (genvar w = 0; w < NWORDS; w++) begin : g_dec
        assign dat_wr[w] = wr_en && (wr_addr == ADDR_W'(A_TXD0 + w));
    end

    canb_tx_path #(.ID_W(ID_W)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr        (wr_en && wr_addr == A_TXCMD),
        .cmd_req       (wr_data[0]),
        .buf_wr_arb    (wr_en && wr_addr == A_TXARB),
        .buf_wr_ctl    (wr_en && wr_addr == A_TXCTL),
        .buf_wr_dat    (dat_wr),
        .wdata         (wr_data),
        .core_idle     (core_idle),
        .core_done     (core_done),
        .core_arb_lost (core_arb_lost),
        .core_err      (core_err),
        .busy          (tx_busy),
        .core_load     (core_load),
        .tx_id         (core_tx_id),
        .tx_dlc        (core_tx_dlc),
        .tx_data       (core_tx_data)
    );

    canb_rx_path #(.ID_W(ID_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (core_rx_valid),
        .snap     (wr_en && wr_addr == A_RXCMD && wr_data[0]),
        .ctl_clr  (wr_en && wr_addr == A_RXCTL),
        .sh_id    (core_sh_id),
        .sh_dlc   (core_sh_dlc),
        .sh_data  (core_sh_data),
        .rx_id    (rx_id),
        .rx_dlc   (rx_dlc),
        .rx_data  (rx_data),
        .newdat   (rx_newdat),
        .msglst   (rx_msglst)
    );

    // read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_TXCMD) rd_data[0] = tx_busy;
        if (rd_addr == A_TXARB) rd_data = HOST_W'(core_tx_id);
        if (rd_addr == A_TXCTL) rd_data = HOST_W'(core_tx_dlc);
        if (rd_addr == A_RXARB) rd_data = HOST_W'(rx_id);
        if (rd_addr == A_RXCTL) begin
            rd_data[DLC_W-1:0]  = rx_dlc;
            rd_data[NEWDAT_BIT] = rx_newdat;
            rd_data[MSGLST_BIT] = rx_msglst;
        end
        for (int w = 0; w < NWORDS; w++) begin
            if (rd_addr == ADDR_W'(A_TXD0 + w)) rd_data = core_tx_data[w*HOST_W +: HOST_W];
            if (rd_addr == ADDR_W'(A_RXD0 + w)) rd_data = rx_data[w*HOST_W +: HOST_W];
        end
    end
endmodule

// File: rtl/canb_ifbuf_ctrl_chk.sv
module canb_ifbuf_ctrl_chk
    import canb_pkg::*;
#(
    parameter int ID_W = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [HOST_W-1:0] wr_data,
    input logic              busy,
    input logic              core_load,
    input logic              core_idle,
    input logic              newdat,
    input logic              msglst,
    input logic [ID_W-1:0]   tx_id,
    input logic [DATA_W-1:0] tx_data
);
    logic abort_wr;
    assign abort_wr = wr_en && wr_addr == A_TXCMD && !wr_data[0];

    AST_LOAD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |-> core_idle && busy); // R4
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |=> !core_load && busy); // R4
    AST_TXBUF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tx_id) && $stable(tx_data)); // R3
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort_wr |=> !busy); // R7
    AST_MSGLST_NEEDS_NEWDAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msglst) |-> $past(newdat) && newdat); // R9
endmodule

bind canb_ifbuf_ctrl canb_ifbuf_ctrl_chk #(.ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (tx_busy),
    .core_load (core_load),
    .core_idle (core_idle),
    .newdat    (rx_newdat),
    .msglst    (rx_msglst),
    .tx_id     (core_tx_id),
    .tx_data   (core_tx_data)
);

// File: tb/canb_ifbuf_ctrl_test.sv
`timescale 1ns/1ps
module canb_ifbuf_ctrl_test;
    import canb_pkg::*;
    localparam int ID_W = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [HOST_W-1:0] wr_data = '0;
    logic [HOST_W-1:0] rd_data;
    logic core_idle = 1'b0, core_done = 1'b0, core_arb_lost = 1'b0, core_err = 1'b0, core_rx_valid = 1'b0;
    logic              core_load;
    logic [ID_W-1:0]   core_tx_id;
    logic [DLC_W-1:0]  core_tx_dlc;
    logic [DATA_W-1:0] core_tx_data;
    logic [ID_W-1:0]   sh_id = '0;
    logic [DLC_W-1:0]  sh_dlc = '0;
    logic [DATA_W-1:0] sh_data = '0;

    canb_ifbuf_ctrl #(.ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .core_idle(core_idle), .core_load(core_load),
        .core_tx_id(core_tx_id), .core_tx_dlc(core_tx_dlc), .core_tx_data(core_tx_data),
        .core_done(core_done), .core_arb_lost(core_arb_lost), .core_err(core_err),
        .core_rx_valid(core_rx_valid), .core_sh_id(sh_id), .core_sh_dlc(sh_dlc),
        .core_sh_data(sh_data)
    );

    int errors = 0;
    int checks = 0;

    // behavioural reference for the transmit side: 0 free, 1 waiting, 2 on bus
    int              m_phase = 0;
    logic [ID_W-1:0] m_id = '0;
    logic [3:0]      m_dlc = '0;
    logic [63:0]     m_data = '0;
    int              m_loads = 0;

    function automatic bit abort_now();
        return wr_en && wr_addr == A_TXCMD && !wr_data[0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_id = '0; m_dlc = '0; m_data = '0;
        end else begin
            if (m_phase == 0 && wr_en) begin
                if (wr_addr == 4'd1) m_id = wr_data[ID_W-1:0];
                if (wr_addr == 4'd2) m_dlc = wr_data[3:0];
                if (wr_addr == 4'd3) m_data[31:0] = wr_data;
                if (wr_addr == 4'd4) m_data[63:32] = wr_data;
            end
            if (m_phase == 0) begin
                if (wr_en && wr_addr == A_TXCMD && wr_data[0]) m_phase = 1;
            end else if (abort_now()) begin
                m_phase = 0;
            end else if (m_phase == 1) begin
                if (core_idle) begin m_phase = 2; m_loads++; end
            end else begin
                if (core_done) m_phase = 0;
                else if (core_arb_lost || core_err) m_phase = 1;
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: compare the load strobe and frame against the reference, then advance
    task automatic tick();
        bit exp_load;
        #0.5;
        exp_load = rst_n && m_phase == 1 && core_idle && !abort_now();
        chk("R4 core_load", {63'd0, core_load}, {63'd0, exp_load});
        if (exp_load) begin
            chk("R4 core_tx_id", 64'(core_tx_id), 64'(m_id));
            chk("R4 core_tx_dlc", 64'(core_tx_dlc), 64'(m_dlc));
            chk("R4 core_tx_data", core_tx_data, m_data);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rdchk(string tag, logic [3:0] a, logic [31:0] exp);
        rd_addr = a;
        #0.2;
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle_pulse();
        core_idle = 1'b1; tick(); core_idle = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        rdchk("R1 TXCMD", 4'd0, 32'd0);
        rdchk("R1 RXARB", 4'd9, 32'd0);
        rdchk("R1 RXCTL", 4'd10, 32'd0);

        // buffer fill while free
        wr(4'd1, 32'h0123_4567);
        wr(4'd2, 32'h0000_0008);
        wr(4'd3, 32'hDEAD_BEEF);
        wr(4'd4, 32'hCAFE_0001);
        rdchk("R3 TXARB free write", 4'd1, 32'h0123_4567);
        rdchk("R3 TXD1 free write", 4'd4, 32'hCAFE_0001);

        // R2 request with junk in upper bits
        wr(4'd0, 32'hFFFF_FF01);
        rdchk("R2 busy set", 4'd0, 32'd1);
        repeat (3) tick();   // bus busy: no load (R4)
        wr(4'd1, 32'h0000_0055);
        wr(4'd3, 32'h0);
        rdchk("R3 TXARB locked", 4'd1, 32'h0123_4567);
        rdchk("R3 TXD0 locked", 4'd3, 32'hDEAD_BEEF);

        idle_pulse();        // first load (R4)
        chk("R4 one load", 64'(m_loads), 64'd1);
        rdchk("R4 busy on bus", 4'd0, 32'd1);

        core_arb_lost = 1'b1; tick(); core_arb_lost = 1'b0;
        rdchk("R6 busy after lost", 4'd0, 32'd1);
        tick(); tick();
        idle_pulse();        // retry load (R6)
        core_err = 1'b1; tick(); core_err = 1'b0;
        rdchk("R6 busy after error", 4'd0, 32'd1);
        idle_pulse();        // second retry (R6)
        chk("R6 three loads", 64'(m_loads), 64'd3);
        core_done = 1'b1; tick(); core_done = 1'b0;
        rdchk("R5 busy cleared", 4'd0, 32'd0);
        wr(4'd1, 32'h0000_0055);
        rdchk("R5 buffer writable", 4'd1, 32'h0000_0055);

        // R7 abort while on bus, then error and idle: no reload
        wr(4'd0, 32'd1);
        idle_pulse();
        wr(4'd0, 32'd0);
        rdchk("R7 abort active", 4'd0, 32'd0);
        core_err = 1'b1; tick(); core_err = 1'b0;
        core_idle = 1'b1; repeat (3) tick(); core_idle = 1'b0;
        chk("R7 no retry after abort", 64'(m_loads), 64'd4);

        // R7 abort while waiting, and abort in the same cycle as idle
        wr(4'd0, 32'd1);
        core_idle = 1'b1;
        wr(4'd0, 32'd0);
        tick(); core_idle = 1'b0;
        rdchk("R7 abort pending", 4'd0, 32'd0);
        chk("R7 abort beats idle", 64'(m_loads), 64'd4);

        // R8 receive store
        sh_id = 29'h1ABC_DEF0; sh_dlc = 4'd5; sh_data = 64'h1111_2222_3333_4444;
        core_rx_valid = 1'b1; tick(); core_rx_valid = 1'b0;
        rdchk("R8 RXARB", 4'd9, 32'h1ABC_DEF0);
        rdchk("R8 RXD0", 4'd11, 32'h3333_4444);
        rdchk("R8 RXD1", 4'd12, 32'h1111_2222);
        rdchk("R8 RXCTL newdat", 4'd10, 32'h0000_8005);
        // R9 overwrite
        sh_id = 29'h0000_0777; sh_dlc = 4'd2;
        core_rx_valid = 1'b1; tick(); core_rx_valid = 1'b0;
        rdchk("R9 RXCTL msglst", 4'd10, 32'h0000_C002);
        rdchk("R9 RXARB newest", 4'd9, 32'h0000_0777);
        // R10 clear
        wr(4'd10, 32'hFFFF_FFFF);
        rdchk("R10 RXCTL cleared", 4'd10, 32'h0000_0002);
        // R11 snapshot mid-frame
        sh_id = 29'h0BAD_0000; sh_dlc = 4'd9; sh_data = 64'h5555_6666_7777_8888;
        wr(4'd8, 32'd1);
        rdchk("R11 snapshot id", 4'd9, 32'h0BAD_0000);
        rdchk("R11 snapshot data", 4'd11, 32'h7777_8888);
        rdchk("R11 flags untouched", 4'd10, 32'h0000_0009);
        sh_id = 29'h0000_0123;
        wr(4'd8, 32'd0);
        rdchk("R11 zero write ignored", 4'd9, 32'h0BAD_0000);
        rdchk("R1 RXCMD reads 0", 4'd8, 32'd0);

        tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule